// File: doc/BRIEF.md
# Two-Modulus Prescaler Divider

This block divides a fast input clock by one of two integer ratios and emits one short pulse per completed division. The short ratio is `P` and the long ratio is `P+M`. With the default `M = 1` the pair is 10/11, and setting `P = 20` gives 20/21. A level input picks the ratio. The pulse stream clocks a slower programmable counter chain downstream. That chain steers the ratio select so that a frame of several divisions adds up to any wanted total.

The ratio for a division is fixed at the clock edge that starts it. Any change to the select after that edge waits for the next division. The counter chain can therefore flip the select at any point inside a division without making the current division shorter or longer. A synchronous active-high reset abandons the current division. The first edge with reset low then starts a fresh one.

Top module: `dual_mod_prescaler`

## Requirements
- R1: While `rst_i` is high at a rising edge of `clk_i`, `pulse_o` is low in the following clock period.
- R2: The first rising edge with `rst_i` low after a reset starts a new division, so `pulse_o` is high in the clock period right after that edge.
- R3: With `div_low_i` high (value 1) at a division's starting edge, that division lasts exactly `P` clock periods. It is measured from one `pulse_o` rising edge to the next.
- R4: With `div_low_i` low (value 0) at a division's starting edge, that division lasts exactly `P+M` clock periods.
- R5: `pulse_o` is high for exactly one clock period per division and has one rising edge per division.
- R6: The value of `div_low_i` at any edge other than a division's starting edge does not change the length of that division.
- R7: Successive divisions may use different ratios. With `P=10`, `M=1`, the select sequence 0,0,0,1 gives four divisions totalling 43 clocks.
- R8: `P` and `M` are parameters. The instances P=20/M=1 (ratios 20 and 21) and P=6/M=3 (ratios 6 and 9) obey R1 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| div_low_i | input | 1 | Ratio select: 1 picks P, 0 picks P+M; taken at each division's start |
| pulse_o | output | 1 | One-clock pulse at the start of every division |

## Verification
The assertions assume that `div_low_i` is a known synchronous level at every rising edge. They also assume that reset is held at time zero for at least one edge, and that `P` is at least 2 so that pulses cannot merge. The stimulus changes `rst_i` and `div_low_i` only on falling edges and holds reset for several edges at start-up and again in mid-run. Besides long runs at one ratio, it changes the select on every falling edge, so that most changes arrive inside a division. The period check in the checker must then ignore those changes.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Length in clocks of one division for a given select level.
  function automatic int unsigned psc_len(input int unsigned p,
                                          input int unsigned m,
                                          input logic        low);
    return low ? p : (p + m);
  endfunction

endpackage

// File: rtl/psc_cycle_ctr.sv
module psc_cycle_ctr
  import psc_pkg::*;
#(
  parameter int unsigned P  = 10,
  parameter int unsigned M  = 1,
  parameter int unsigned CW = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic div_low_i,
  output logic start_o
);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [CW-1:0] load_val;

  // Remaining-count value loaded at a division start; the select is
  // consumed only here, which freezes the ratio for the division.
  generate
    if (M == 0) begin : g_single
      assign load_val = CW'(P - 1);
    end else begin : g_dual
      assign load_val = CW'(psc_len(P, M, div_low_i) - 1);
    end
  endgenerate

  assign start_o = !run_q || (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_o) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/psc_pulse_gen.sv
module psc_pulse_gen (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  output logic pulse_o
);

  logic pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_q <= 1'b0;
    else       pulse_q <= start_i;
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int unsigned P = 10,
  parameter int unsigned M = 1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic div_low_i,
  output logic pulse_o
);

  localparam int unsigned LMAX = P + M;
  localparam int unsigned CW   = (LMAX < 2) ? 1 : $clog2(LMAX);

  logic start;

  psc_cycle_ctr #(.P(P), .M(M), .CW(CW)) u_ctr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .div_low_i (div_low_i),
    .start_o   (start)
  );

  psc_pulse_gen u_pulse (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start),
    .pulse_o (pulse_o)
  );

endmodule

// File: rtl/psc_checker.sv
module psc_checker
  import psc_pkg::*;
#(
  parameter int unsigned P = 10,
  parameter int unsigned M = 1
) (
  input logic clk_i,
  input logic rst_i,
  input logic div_low_i,
  input logic pulse_o,
  input logic start_i
);

  logic sel_d;
  logic seen;
  int   gap;
  int   exp_len;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sel_d   <= 1'b0;
      seen    <= 1'b0;
      gap     <= 0;
      exp_len <= 0;
    end else begin
      sel_d <= div_low_i;
      if (pulse_o) begin
        seen    <= 1'b1;
        gap     <= 1;
        exp_len <= int'(psc_len(P, M, sel_d));
      end else begin
        gap <= gap + 1;
      end
    end
  end

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    rst_i |=> !pulse_o);

  // R2
  a_r2_fresh_start: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(rst_i) && !rst_i) |=> pulse_o);

  // R3 and R4: the spacing matches the select held at the starting edge
  a_r4_period: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen && pulse_o) |-> (gap == exp_len));

  // R6: a select change inside a division never ends it early or late
  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen && !pulse_o) |-> (gap < exp_len));

  // R5
  a_r5_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  // R5: every division start produces the pulse
  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |=> pulse_o);

endmodule

bind dual_mod_prescaler psc_checker #(.P(P), .M(M)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .div_low_i (div_low_i),
  .pulse_o   (pulse_o),
  .start_i   (start)
);

// File: tb/dual_mod_prescaler_bench.sv
`timescale 1ns/1ps
module dual_mod_prescaler_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic pulse_a, pulse_b, pulse_c;

  always #10 clk = ~clk;   // 50 MHz

  dual_mod_prescaler u_dual_mod_prescaler (
    .clk_i(clk), .rst_i(rst), .div_low_i(sel), .pulse_o(pulse_a));

  dual_mod_prescaler #(.P(20), .M(1)) u_p20 (
    .clk_i(clk), .rst_i(rst), .div_low_i(sel), .pulse_o(pulse_b));

  dual_mod_prescaler #(.P(6), .M(3)) u_p6m3 (
    .clk_i(clk), .rst_i(rst), .div_low_i(sel), .pulse_o(pulse_c));

  int    checks = 0;
  int    errs   = 0;
  string tag    = "R1";
  bit    armed  = 1'b0;
  bit    done   = 1'b0;

  // Behavioural reference: edge numbers at which each division begins.
  int pp [3] = '{10, 20, 6};
  int mm [3] = '{1, 1, 3};
  int cyc = 0;
  int next_start [3];
  bit exp_q [3];
  bit prev [3];

  always @(posedge clk) begin
    cyc = cyc + 1;
    for (int i = 0; i < 3; i++) begin
      if (rst) begin
        next_start[i] = cyc + 1;
        exp_q[i] = 1'b0;
      end else if (cyc == next_start[i]) begin
        exp_q[i] = 1'b1;
        next_start[i] = cyc + (sel ? pp[i] : pp[i] + mm[i]);
      end else begin
        exp_q[i] = 1'b0;
      end
    end
    armed = 1'b1;
  end

  function automatic string inst_tag(int i);
    return (i == 0) ? tag : {tag, "/R8"};
  endfunction

  always @(negedge clk) begin
    if (armed && !done) begin
      logic got [3];
      got[0] = pulse_a; got[1] = pulse_b; got[2] = pulse_c;
      for (int i = 0; i < 3; i++) begin
        checks++;
        if (got[i] !== exp_q[i]) begin
          errs++;
          $display("FAIL %s inst%0d pulse actual=%b expected=%b at edge %0d",
                   inst_tag(i), i, got[i], exp_q[i], cyc);
        end
        if (got[i] === 1'b1) begin
          checks++;
          if (prev[i]) begin
            errs++;
            $display("FAIL R5 inst%0d pulse wider than one clock actual=2+ expected=1", i);
          end
        end
        prev[i] = (got[i] === 1'b1);
      end
    end
  end

  task automatic wait_pulse(output int stamp);
    do @(negedge clk); while (pulse_a !== 1'b1);
    stamp = cyc;
  endtask

  initial begin
    int s0, s1, s2, s3, s4, s5;
    tag = "R1"; rst = 1'b1; sel = 1'b0;
    repeat (4) @(negedge clk);
    tag = "R2"; rst = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R4"; sel = 1'b0;
    repeat (70) @(negedge clk);
    tag = "R3"; sel = 1'b1;
    repeat (70) @(negedge clk);
    tag = "R6";
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      sel = ((k * 7) % 5) < 2;
    end
    // R7: three long divisions then one short one total 43 clocks
    tag = "R7";
    sel = 1'b0;
    wait_pulse(s0); sel = 1'b0;
    wait_pulse(s1); sel = 1'b0;
    wait_pulse(s2); sel = 1'b0;
    wait_pulse(s3); sel = 1'b1;
    wait_pulse(s4); sel = 1'b0;
    wait_pulse(s5);
    checks++;
    if (s5 - s1 != 3 * 11 + 10) begin
      errs++;
      $display("FAIL R7 frame length actual=%0d expected=%0d", s5 - s1, 43);
    end
    repeat (30) @(negedge clk);
    tag = "R1"; rst = 1'b1; sel = 1'b1;
    repeat (5) @(negedge clk);
    tag = "R2"; rst = 1'b0;
    repeat (40) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule